// File: doc/BRIEF.md
# Handshaked byte receiver with interleaved buffers

The block takes in a block of bytes from a peer over an 8-bit parallel bus. The peer offers a byte by raising a valid line, and the block answers on a single acknowledge line. Every byte it accepts goes out on a byte-wide memory write port as one write, with an address and a write enable, so the port can drive a simple RAM.

After reset the block sends a one-cycle acknowledge pulse to tell the peer it is ready. The first byte it accepts is a length. That byte is written to a fixed location and is not counted as data. The data bytes that follow go alternately to two regions, and each region has its own pointer that steps after every write to that region. The length is limited to a maximum block size. Once the last data byte is stored, a done flag rises and stays high, and the bus is then ignored until the next reset.

Top module: `bhr_rx_top`

## Requirements
- R1: Reset state: `rx_ack` is 0. After reset is released, `rx_ack` is 1 for exactly one cycle and then returns to 0. No write happens during this sequence.
- R2: When ready and `rx_valid` is 1 at a clock edge, the block captures `rx_data`. `mem_we` is then 1 for exactly one cycle, with `mem_wdata` equal to the captured byte.
- R3: `rx_ack` rises in the same cycle as the capture write. It stays 1 for exactly ACK_HOLD+1 cycles (3 with the defaults), then returns to 0.
- R4: After an acknowledge, no byte is captured until `rx_valid` has been seen at 0 and then at 1 again. If `rx_valid` is held at 1, there is no further write and no further acknowledge.
- R5: The first byte after reset is the length. It is written to address CNT_ADDR (20h) and is not counted as data.
- R6: Data bytes are written alternately to two regions. The first data byte goes to BASE_A (31h), the second to BASE_B (61h), and so on, each region's address rising by 1 after each of its own writes.
- R7: A length greater than MAX_LEN (61) is treated as MAX_LEN, so exactly MAX_LEN data bytes are accepted. The length byte itself is still stored unchanged.
- R8: `done` rises in the cycle where `rx_ack` falls after the last data byte. With a length of 0, this is after the length byte. `done` is 0 before that point.
- R9: While `done` is 1, `rx_valid` is ignored: `mem_we` and `rx_ack` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | DATA_W | Byte offered by the peer |
| rx_valid | input | 1 | Peer has a byte on rx_data |
| rx_ack | output | 1 | Readiness pulse, then acknowledge of each byte |
| mem_we | output | 1 | Write enable of the buffer memory port |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| done | output | 1 | Block fully received |

## Verification
The assertions expect nothing from the peer except that its inputs are synchronous to `clk`. Each capture is tied to `rx_valid` having been high at the capture edge. An acknowledge run is bounded by a counter rather than a long delay. The stimulus changes `rx_data` and `rx_valid` only on falling edges, and drops valid as soon as acknowledge is seen. One byte deliberately holds valid high through and after its acknowledge, to show that a second capture needs a fresh low-to-high change of valid.

// File: rtl/bhr_pkg.sv
package bhr_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_PULSE,
    ST_WAIT_LO,
    ST_ARMED,
    ST_ACK,
    ST_FIN
  } bhr_state_t;
endpackage

// File: rtl/bhr_seq.sv
module bhr_seq
  import bhr_pkg::*;
#(
  parameter int ACK_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic last_now,
  output logic capture,
  output logic hdr,
  output logic ack,
  output logic done
);
  localparam int HOLD_W = (ACK_HOLD < 1) ? 1 : $clog2(ACK_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(ACK_HOLD);

  bhr_state_t st;
  logic [HOLD_W-1:0] hcnt;
  logic fin;

  always_comb capture = (st == ST_ARMED) && rx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_BOOT;
      ack  <= 1'b0;
      done <= 1'b0;
      hdr  <= 1'b1;
      fin  <= 1'b0;
      hcnt <= '0;
    end else begin
      case (st)
        ST_BOOT: begin
          ack <= 1'b1;
          st  <= ST_PULSE;
        end
        ST_PULSE: begin
          ack <= 1'b0;
          st  <= ST_WAIT_LO;
        end
        ST_WAIT_LO: begin
          if (!rx_valid) st <= ST_ARMED;
        end
        ST_ARMED: begin
          if (capture) begin
            ack  <= 1'b1;
            hcnt <= '0;
            fin  <= last_now;
            hdr  <= 1'b0;
            st   <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (hcnt == HOLD_LAST) begin
            ack <= 1'b0;
            if (fin) begin
              done <= 1'b1;
              st   <= ST_FIN;
            end else begin
              st <= ST_WAIT_LO;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= ST_FIN;
      endcase
    end
  end
endmodule

// File: rtl/bhr_addr.sv
module bhr_addr #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 7'h20,
  parameter logic [ADDR_W-1:0] BASE_A = 7'h31,
  parameter logic [ADDR_W-1:0] BASE_B = 7'h61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              hdr,
  output logic [ADDR_W-1:0] addr_nxt
);
  localparam int NREG = 2;

  logic [ADDR_W-1:0] ptr [NREG];
  logic sel;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    localparam logic [ADDR_W-1:0] BASE = (g == 0) ? BASE_A : BASE_B;
    always_ff @(posedge clk) begin
      if (rst) ptr[g] <= BASE;
      else if (capture && !hdr && (sel == g[0])) ptr[g] <= ptr[g] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel <= 1'b0;
    else if (capture && !hdr) sel <= ~sel;
  end

  always_comb addr_nxt = hdr ? CNT_ADDR : ptr[sel];
endmodule

// File: rtl/bhr_remain.sv
module bhr_remain #(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              hdr,
  input  logic [DATA_W-1:0] cnt_byte,
  output logic              last_now
);
  localparam logic [DATA_W-1:0] MAXV = DATA_W'(MAX_LEN);

  logic [DATA_W-1:0] rem;
  logic [DATA_W-1:0] clamp;

  always_comb begin
    clamp    = (cnt_byte > MAXV) ? MAXV : cnt_byte;
    last_now = hdr ? (clamp == '0) : (rem == DATA_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) rem <= '0;
    else if (capture) rem <= hdr ? clamp : rem - 1'b1;
  end
endmodule

// File: rtl/bhr_rx_top.sv
module bhr_rx_top #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int MAX_LEN  = 61,
  parameter int ACK_HOLD = 2,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 7'h20,
  parameter logic [ADDR_W-1:0] BASE_A = 7'h31,
  parameter logic [ADDR_W-1:0] BASE_B = 7'h61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ack,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done
);
  logic capture, hdr, last_now;
  logic [ADDR_W-1:0] addr_nxt;

  bhr_seq #(.ACK_HOLD(ACK_HOLD)) u_seq (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .last_now(last_now),
    .capture(capture), .hdr(hdr), .ack(rx_ack), .done(done)
  );

  bhr_addr #(
    .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR), .BASE_A(BASE_A), .BASE_B(BASE_B)
  ) u_addr (
    .clk(clk), .rst(rst), .capture(capture), .hdr(hdr), .addr_nxt(addr_nxt)
  );

  bhr_remain #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_rem (
    .clk(clk), .rst(rst), .capture(capture), .hdr(hdr),
    .cnt_byte(rx_data), .last_now(last_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= capture;
      if (capture) begin
        mem_addr  <= addr_nxt;
        mem_wdata <= rx_data;
      end
    end
  end
endmodule

// File: rtl/bhr_rx_chk.sv
module bhr_rx_chk #(
  parameter int ACK_HOLD = 2
) (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic rx_ack,
  input logic mem_we,
  input logic done
);
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (!rx_ack) run <= '0;
    else if (run != 8'hFF) run <= run + 1'b1;
  end

  // R2
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R3
  we_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> rx_ack);

  // R3
  ack_len_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ack |-> (32'(run) < ACK_HOLD + 1));

  // R4
  capt_valid_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(rx_valid));

  // R8
  done_at_ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(rx_ack));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !rx_ack));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
endmodule

bind bhr_rx_top bhr_rx_chk #(.ACK_HOLD(ACK_HOLD)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ack(rx_ack),
  .mem_we(mem_we), .done(done)
);

// File: tb/tb_bhr_rx_top.sv
module tb_bhr_rx_top;
  localparam int CLK_P = 10;
  localparam int HOLD  = 2;

  logic clk = 0;
  logic rst = 1;
  logic [7:0] rx_data = '0;
  logic rx_valid = 0;
  logic rx_ack, mem_we, done;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;

  int nvec = 0;
  int nfail = 0;
  logic [14:0] expq [$];

  bhr_rx_top dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ack(rx_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      nvec++;
      if (expq.size() == 0) begin
        nfail++;
        $display("FAIL R4 unexpected write actual=%0h:%0h expected=none", mem_addr, mem_wdata);
      end else begin
        logic [14:0] e;
        e = expq.pop_front();
        if ({mem_addr, mem_wdata} != e) begin
          nfail++;
          $display("FAIL %s write actual=%0h:%0h expected=%0h:%0h",
                   (e[14:8] == 7'h20) ? "R5" : "R6", mem_addr, mem_wdata, e[14:8], e[7:0]);
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1; rx_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(rx_ack == 0 && mem_we == 0 && done == 0, "R1 reset", {rx_ack, mem_we, done}, 0);
    @(negedge clk);
    check(rx_ack == 1, "R1 pulse high", rx_ack, 1);
    @(negedge clk);
    check(rx_ack == 0 && !mem_we, "R1 pulse low", rx_ack, 0);
  endtask

  task automatic send(input logic [7:0] d, input logic [6:0] a, input bit extra,
                      input bit exp_done);
    int hi;
    expq.push_back({a, d});
    @(negedge clk);
    rx_data = d; rx_valid = 1;
    while (!rx_ack) @(negedge clk);
    if (!extra) rx_valid = 0;
    hi = 0;
    while (rx_ack) begin hi++; @(negedge clk); end
    check(hi == HOLD + 1, "R3 ack width", hi, HOLD + 1);
    check(done == exp_done, "R8 done", done, exp_done);
    if (extra) begin
      repeat (5) begin
        @(negedge clk);
        check(!rx_ack, "R4 held valid no ack", rx_ack, 0);
      end
      rx_valid = 0;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    // block of 4, one byte holds valid high (R2, R4, R5, R6)
    do_reset();
    send(8'd4, 7'h20, 0, 0);
    send(8'hA1, 7'h31, 1, 0);
    send(8'hB2, 7'h61, 0, 0);
    send(8'hC3, 7'h32, 0, 0);
    send(8'hD4, 7'h62, 0, 1);
    check(expq.size() == 0, "R2 all writes seen", expq.size(), 0);

    // R9: valid ignored after done
    @(negedge clk);
    rx_data = 8'h5A; rx_valid = 1;
    repeat (8) begin
      @(negedge clk);
      check(!rx_ack && !mem_we && done, "R9 ignored", {rx_ack, mem_we, done}, 1);
    end
    rx_valid = 0;

    // zero length (R8)
    do_reset();
    send(8'd0, 7'h20, 0, 1);
    @(negedge clk);
    rx_valid = 1;
    repeat (6) begin
      @(negedge clk);
      check(!rx_ack && done, "R9 after zero length", rx_ack, 0);
    end
    rx_valid = 0;

    // single byte
    do_reset();
    send(8'd1, 7'h20, 0, 0);
    send(8'h77, 7'h31, 0, 1);

    // R7: oversized length clamped to 61
    do_reset();
    send(8'd70, 7'h20, 0, 0);
    for (int i = 0; i < 61; i++) begin
      logic [6:0] a;
      a = (i % 2 == 0) ? 7'(7'h31 + i / 2) : 7'(7'h61 + i / 2);
      send(8'(i + 16), a, 0, i == 60);
    end
    check(done == 1, "R7 done after 61", done, 1);
    check(expq.size() == 0, "R7 all writes seen", expq.size(), 0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule